// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Byte-Lane Bypass

This block is a single-port synchronous memory with a deferred write path. Commands (address, select, a global write strobe and one write strobe per byte lane) are captured on the rising clock edge. The write data for a command is taken at the following rising edge. A write does not reach the storage array at once. It waits in a holding entry and is committed when the next write with a different address delivers its data. Back-to-back writes to one address fold their enabled lanes into the same holding entry.

Each read address is compared with the holding entry. On a match, every lane that the pending write enabled comes from the holding entry and every other lane comes from the array, so a read always returns the latest written contents. Read results are latched into an output stage on the falling clock edge.

A registered sleep input and an asynchronous output enable both turn the output drive off. Stored contents are kept in sleep, and a write whose data is already in flight still completes. High impedance is modelled by a drive flag, with the data bus held at zero while the flag is low.

Top module: `latewrite_sram`

## Requirements
- R1: A read command (sel=1, wrEn=0, sleep=0) captured at a rising edge presents the stored word on dataOut, with dataDrive high, from the following falling edge until the next falling edge, provided outEn is high.
- R2: The data for a write command captured at rising edge N is taken from dataIn at rising edge N+1. dataIn is ignored at every other edge.
- R3: laneWe[i] selects bits 9i+8..9i of the word (lane 0 = bits 8..0, lane 3 = bits 35..27). Only enabled lanes change. A write with laneWe=0 changes nothing, and a read command carrying lane strobes writes nothing.
- R4: A read whose address matches the pending write returns the pending lanes merged over the array lanes, including a read captured at the same edge that delivers the write data.
- R5: Consecutive writes to one address accumulate their enabled lanes. Reads return the union, before and after a later write to another address commits the entry.
- R6: A cycle with sel=0 neither reads nor writes: dataDrive is low after it. A write already waiting for its data still completes.
- R7: A command captured with sleep=1 is ignored and dataDrive stays low. Contents are kept, and write data already in flight is still taken.
- R8: outEn=0 forces dataDrive low and dataOut to zero at once, without a clock. Restoring outEn shows the latched word again.
- R9: During and right after reset, dataDrive is low, dataOut is zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands sampled on the rising edge, outputs updated on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Synchronous select; low makes the cycle a no-op |
| wrEn | input | 1 | Global write strobe; low means read |
| laneWe | input | LANES | Per-lane write strobes, lane i = bits 9i+8..9i |
| addr | input | ADDR_W | Word address |
| dataIn | input | LANES*LANE_W | Write data, taken one cycle after its command |
| sleep | input | 1 | Synchronous sleep request |
| outEn | input | 1 | Asynchronous output enable, active high |
| dataOut | output | LANES*LANE_W | Read data, zero when not driven |
| dataDrive | output | 1 | High when dataOut is actively driven |

## Verification
The bench builds the block with ADDR_W=4, LANES=4 and LANE_W=9, a 16-word array of 36-bit words. With so few addresses, random traffic repeatedly hits the holding entry with reads of the same address, same-address write chains that merge lanes, and commits to other addresses. Directed sequences cover the read issued in the data cycle, sleep during a data cycle, deselected cycles between a command and its data, and toggling the output enable between clock edges.

// File: rtl/lws_pkg.sv
package lws_pkg;

  // Strobes from control to datapath, valid for the coming rising edge
  // (arrive, commit) or the coming falling edge (rdLatch).
  typedef struct packed {
    logic arrive;   // write data is on dataIn this cycle
    logic commit;   // holding entry goes to the array this edge
    logic rdLatch;  // a read was captured; latch merged word at falling edge
  } lws_strobe_t;

endpackage

// File: rtl/lws_ctrl.sv
module lws_ctrl
  import lws_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [LANES-1:0]  laneWe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sleep,
  output lws_strobe_t       stb,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [LANES-1:0]  commitMask,
  output logic [LANES-1:0]  arriveMask,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LANES-1:0]  bypassMask,
  output logic              pendValid,
  output logic              sleepReg
);

  logic              accept;
  logic              cmdRd;
  logic [ADDR_W-1:0] cmdAddr;
  logic              wWait;
  logic [ADDR_W-1:0] wAddr;
  logic [LANES-1:0]  wMask;
  logic [ADDR_W-1:0] pendAddr;
  logic [LANES-1:0]  pendMask;
  logic              sameAddr;
  logic              rdHit;

  assign accept = sel & ~sleep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepReg  <= 1'b0;
      cmdRd     <= 1'b0;
      cmdAddr   <= '0;
      wWait     <= 1'b0;
      wAddr     <= '0;
      wMask     <= '0;
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendMask  <= '0;
    end else begin
      sleepReg <= sleep;
      cmdRd    <= accept & ~wrEn;
      if (accept) cmdAddr <= addr;
      wWait    <= accept & wrEn;
      if (accept && wrEn) begin
        wAddr <= addr;
        wMask <= laneWe;
      end
      if (wWait) begin
        pendValid <= 1'b1;
        pendAddr  <= wAddr;
        pendMask  <= sameAddr ? (pendMask | wMask) : wMask;
      end
    end
  end

  always_comb begin
    sameAddr    = pendValid && (pendAddr == wAddr);
    rdHit       = pendValid && (pendAddr == cmdAddr);
    stb.arrive  = wWait;
    stb.commit  = wWait && pendValid && !sameAddr;
    stb.rdLatch = cmdRd;
    commitAddr  = pendAddr;
    commitMask  = pendMask;
    arriveMask  = wMask;
    rdAddr      = cmdAddr;
    bypassMask  = rdHit ? pendMask : '0;
  end

endmodule

// File: rtl/lws_dpath.sv
module lws_dpath
  import lws_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lws_strobe_t             stb,
  input  logic [ADDR_W-1:0]       commitAddr,
  input  logic [LANES-1:0]        commitMask,
  input  logic [LANES-1:0]        arriveMask,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES-1:0]        bypassMask,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    sleepReg,
  input  logic                    outEn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] doutReg;
  logic              rdHeld;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] pendLane;

    always_ff @(posedge clk) begin
      if (stb.commit && commitMask[l])
        laneMem[commitAddr] <= pendLane;
      if (stb.arrive && arriveMask[l])
        pendLane <= dataIn[l*LANE_W +: LANE_W];
    end

    assign merged[l*LANE_W +: LANE_W] = bypassMask[l] ? pendLane : laneMem[rdAddr];
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      doutReg <= '0;
      rdHeld  <= 1'b0;
    end else begin
      rdHeld <= stb.rdLatch;
      if (stb.rdLatch) doutReg <= merged;
    end
  end

  assign dataDrive = rdHeld & ~sleepReg & outEn;
  assign dataOut   = dataDrive ? doutReg : '0;

endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram
  import lws_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sel,
  input  logic                    wrEn,
  input  logic [LANES-1:0]        laneWe,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    sleep,
  input  logic                    outEn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);

  lws_strobe_t       stb;
  logic [ADDR_W-1:0] commitAddr;
  logic [LANES-1:0]  commitMask;
  logic [LANES-1:0]  arriveMask;
  logic [ADDR_W-1:0] rdAddr;
  logic [LANES-1:0]  bypassMask;
  logic              pendValid;
  logic              sleepReg;

  lws_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .laneWe(laneWe),
    .addr(addr), .sleep(sleep), .stb(stb), .commitAddr(commitAddr),
    .commitMask(commitMask), .arriveMask(arriveMask), .rdAddr(rdAddr),
    .bypassMask(bypassMask), .pendValid(pendValid), .sleepReg(sleepReg)
  );

  lws_dpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .commitAddr(commitAddr),
    .commitMask(commitMask), .arriveMask(arriveMask), .rdAddr(rdAddr),
    .bypassMask(bypassMask), .dataIn(dataIn), .sleepReg(sleepReg),
    .outEn(outEn), .dataOut(dataOut), .dataDrive(dataDrive)
  );

endmodule

// File: rtl/lws_checker.sv
module lws_checker #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              sel,
  input logic              wrEn,
  input logic              sleep,
  input logic              outEn,
  input logic              dataDrive,
  input logic [WORD_W-1:0] dataOut,
  input logic              pendValid
);

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !wrEn && !sleep) |=> (dataDrive == outEn));

  assert_write_pends_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn && !sleep) |-> ##2 pendValid);

  assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> !dataDrive);

  assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !dataDrive);

  always_comb begin
    if (rstN && dataDrive) assert_oe_gate_R8: assert (outEn);
  end

  always @(posedge clk) begin
    if (!rstN) assert_reset_quiet_R9: assert (!dataDrive && dataOut == '0 && !pendValid);
  end

endmodule

bind latewrite_sram lws_checker #(.WORD_W(LANES*LANE_W)) chk_i (
  .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .sleep(sleep),
  .outEn(outEn), .dataDrive(dataDrive), .dataOut(dataOut),
  .pendValid(pendValid)
);

// File: tb/latewrite_sram_tb.sv
module latewrite_sram_tb_top;

  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sel = 1'b0, wrEn = 1'b0, sleep = 1'b0, outEn = 1'b1;
  logic [NL-1:0] laneWe = '0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] dataIn = '0;
  logic [WW-1:0] dataOut;
  logic          dataDrive;

  latewrite_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .laneWe(laneWe),
    .addr(addr), .dataIn(dataIn), .sleep(sleep), .outEn(outEn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [WW-1:0] refMem [DEPTH];
  logic          prevWr = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  logic [NL-1:0] prevMask = '0;

  function automatic logic [WW-1:0] applyLanes(logic [WW-1:0] old, logic [WW-1:0] nw,
                                               logic [NL-1:0] m);
    logic [WW-1:0] r = old;
    for (int l = 0; l < NL; l++)
      if (m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic sl,
                      input logic [AW-1:0] a, input logic [NL-1:0] m, input string req);
    logic [WW-1:0] din;
    logic isRead;
    din = {4'($urandom()), 32'($urandom())};
    sel = s; wrEn = w; sleep = sl; addr = a; laneWe = m; dataIn = din;
    @(posedge clk);
    if (prevWr) refMem[prevAddr] = applyLanes(refMem[prevAddr], din, prevMask);
    isRead   = s && !sl && !w;
    prevWr   = s && !sl && w;
    prevAddr = a;
    prevMask = m;
    #15;
    check(dataDrive == (isRead && outEn), {req, " drive"}, WW'(dataDrive), WW'(isRead && outEn));
    if (isRead && outEn) check(dataOut == refMem[a], {req, " data"}, dataOut, refMem[a]);
    else                 check(dataOut == '0, {req, " idle bus"}, dataOut, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    step(1'b1, 1'b0, 1'b0, a, 4'h0, req);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] m, input string req);
    step(1'b1, 1'b1, 1'b0, a, m, req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 1'b0, 1'b0, '0, 4'h0, req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #5;
    check(!dataDrive && dataOut == '0, "R9 in reset", dataOut, '0);
    rstN = 1'b1;
    @(posedge clk); #15;
    check(!dataDrive && dataOut == '0, "R9 after reset", dataOut, '0);

    // Fill every word with a full-lane write
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), 4'hF, "R2 fill");
    idle("R6 fill tail");
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R1 readback");

    // R4: read issued in the data cycle, partial lanes merged over array
    wr(4'd3, 4'b0101, "R4 write");
    rd(4'd3, "R4 bypass same edge");
    rd(4'd3, "R4 bypass");

    // R5: same-address chain then commit by another address
    wr(4'd3, 4'b0010, "R5 write a");
    wr(4'd3, 4'b1000, "R5 write b");
    rd(4'd3, "R5 union");
    wr(4'd7, 4'hF, "R5 other");
    rd(4'd3, "R5 after commit");
    rd(4'd7, "R5 new pending");

    // R6: deselect cycles around a write's data cycle
    wr(4'd9, 4'hF, "R6 write");
    idle("R6 deselect data cycle");
    idle("R6 deselect");
    rd(4'd9, "R6 read after deselect");

    // R7: sleep in data cycle, and a write command given in sleep
    wr(4'd10, 4'hF, "R7 write");
    step(1'b1, 1'b0, 1'b1, 4'd10, 4'h0, "R7 sleep read");
    rd(4'd10, "R7 data kept");
    step(1'b1, 1'b1, 1'b1, 4'd11, 4'hF, "R7 sleep write");
    idle("R7 idle");
    rd(4'd11, "R7 unchanged");

    // R3: read with lane strobes, write with no lanes
    step(1'b1, 1'b0, 1'b0, 4'd2, 4'hF, "R3 read with strobes");
    rd(4'd2, "R3 no write");
    wr(4'd4, 4'h0, "R3 empty mask");
    rd(4'd4, "R3 empty mask unchanged");
    wr(4'd5, 4'b0001, "R3 lane0");
    wr(4'd6, 4'b1000, "R3 lane3");
    rd(4'd5, "R3 lane0 read");
    rd(4'd6, "R3 lane3 read");

    // R8: asynchronous output enable
    rd(4'd5, "R8 read");
    outEn = 1'b0; #1;
    check(!dataDrive && dataOut == '0, "R8 forced off", dataOut, '0);
    outEn = 1'b1; #1;
    check(dataDrive && dataOut == refMem[5], "R8 restored", dataOut, refMem[5]);

    // Random traffic over a small address space
    for (int i = 0; i < 3000; i++) begin
      logic s, w, sl;
      s  = ($urandom_range(0, 9) != 0);
      w  = $urandom_range(0, 1) == 1;
      sl = ($urandom_range(0, 19) == 0);
      outEn = ($urandom_range(0, 15) != 0);
      step(s, w, sl, AW'($urandom_range(0, 3)), NL'($urandom()), "R1 R4 R5 random");
    end
    outEn = 1'b1;
    idle("R2 final");

    finished = 1;
    summary();
    $finish;
  end

endmodule